// File: doc/BRIEF.md
# Bus-Master Disk DMA Engine

This block is a single bus-master DMA channel for a parallel disk port. A host programs it through an eight-byte register window. The window holds a command byte, a status byte and a 32-bit pointer to a table of region descriptors in memory. When the start bit is set, the engine reads descriptors through a simple memory read port. Each descriptor names a physical base address and a byte count. For each one, the engine moves the region in fixed-size beats over a request/acknowledge handshake with the drive-side FIFO, tagging each beat with the programmed direction.

When the last region has been moved, the engine keeps its active flag set until the drive signals completion. It then clears the active flag and raises its interrupt flag. The host checks the low three status bits for the clean-finish pattern and clears the interrupt and error flags by writing them back as ones. Two further status bits are plain storage that software uses to mark each of the two drives as able to do DMA.

Top module: `bmd_engine`

## Requirements
- R1: After reset every byte of the window reads 0, irq_o is low, and neither mem_req_o nor xfer_req_o is asserted.
- R2: The window places the command byte at offset 0, the status byte at offset 2, and the table pointer at offsets 4 to 7, least significant byte first. Pointer bits 1:0 always read 0. Offsets 1 and 3 read 0, and writes to them change nothing.
- R3: Writing command bit 0 as 1 while it is 0 starts the engine: the first descriptor word is fetched at the pointer. Writing bit 0 as 0 stops the engine at once: active clears and no further memory or transfer requests appear.
- R4: Command bit 3 sets the direction, with 1 meaning data is written to memory; it is driven on xfer_wr_mem_o during every beat. A write to bit 3 is ignored while bit 0 is 1.
- R5: Status bit 0 (active) is read-only. It is 1 from the start write until a stop, a fetch error or completion.
- R6: Status bits 1 (error) and 2 (interrupt) clear when written as 1 and are unchanged when written as 0. A hardware set in the same cycle as a clear wins.
- R7: Status bits 5 and 6 are plain read/write bits and hold whatever value was last written to them.
- R8: Descriptor k occupies two words at pointer+8k and pointer+8k+4. The first word is the base address. The second word holds the byte count in bits 15:0 and the last-entry marker in bit 31. A region of n bytes is moved as ceil(n/4) beats at base, base+4, and so on; the next descriptor is then fetched.
- R9: A count field of 0 moves 65536 bytes (16384 beats).
- R10: When the drive interrupts after the last region is done, the low three status bits become 100b and irq_o goes high. Until then, after the last beat, they read 001b.
- R11: When the drive interrupts while regions remain, the interrupt bit sets, active stays 1 and the transfer continues.
- R12: A memory error response to a descriptor fetch sets the error bit, clears active and ends all requests, so the low three status bits read 010b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Byte offset in the register window |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_ack_i | input | 1 | Descriptor read response valid |
| mem_err_i | input | 1 | Response carries an error (qualified by mem_ack_i) |
| mem_rdata_i | input | 32 | Descriptor word, little-endian value |
| xfer_req_o | output | 1 | Data beat request toward the drive FIFO |
| xfer_addr_o | output | 32 | Memory address of the current beat |
| xfer_wr_mem_o | output | 1 | Beat direction: 1 writes memory |
| xfer_ack_i | input | 1 | Drive FIFO accepts the beat |
| drive_irq_i | input | 1 | Drive completion pulse |
| irq_o | output | 1 | Interrupt flag (status bit 2) |

## Verification
The properties assume that memory responses arrive only while mem_req_o is high, that a response error comes with mem_ack_i, and that xfer_ack_i is raised only against a pending xfer_req_o. The stimulus keeps within these limits: both responders are driven on the falling edge and gate their acknowledge on the request they observe. The drive pulses its interrupt only at chosen points, either mid-transfer or after the last beat. Descriptor tables are built in a bench-side memory, and the expected beat addresses and counts are derived arithmetically from the descriptor lengths over a sweep of small lengths in both directions.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int OFS_CMD = 0;
  localparam int OFS_STS = 2;
  localparam int OFS_PTR = 4;
  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_DIR_BIT = 3;
  localparam int STS_ACT_BIT = 0;
  localparam int STS_ERR_BIT = 1;
  localparam int STS_INT_BIT = 2;
  localparam int STS_CAP_LO = 5;
  localparam int DESC_LAST_BIT = 31;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH_BASE,
    W_FETCH_CNT,
    W_MOVE,
    W_DRAIN
  } walk_state_e;
endpackage

// File: rtl/bmd_regs.sv
module bmd_regs
  import bmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic              fault_i,
  input  logic              drive_irq_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              intr_o
);
  localparam int PTR_BYTES = ADDR_W / 8;

  logic              run_q, dir_q, err_q, intr_q;
  logic [1:0]        cap_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              cmd_wr, sts_wr;

  assign cmd_wr  = wr_i && (addr_i == 3'(OFS_CMD));
  assign sts_wr  = wr_i && (addr_i == 3'(OFS_STS));
  assign start_o = cmd_wr && wdata_i[CMD_RUN_BIT] && !run_q;
  assign stop_o  = cmd_wr && !wdata_i[CMD_RUN_BIT] && run_q;
  assign dir_o   = dir_q;
  assign ptr_o   = ptr_q;
  assign intr_o  = intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      intr_q <= 1'b0;
      cap_q  <= 2'b00;
    end else begin
      if (cmd_wr) begin
        run_q <= wdata_i[CMD_RUN_BIT];
        if (!run_q) dir_q <= wdata_i[CMD_DIR_BIT];
      end
      if (sts_wr) cap_q <= wdata_i[STS_CAP_LO+1:STS_CAP_LO];
      // hardware set beats software clear
      if (fault_i) err_q <= 1'b1;
      else if (sts_wr && wdata_i[STS_ERR_BIT]) err_q <= 1'b0;
      if (drive_irq_i) intr_q <= 1'b1;
      else if (sts_wr && wdata_i[STS_INT_BIT]) intr_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ptr
    localparam logic [7:0] MASK = (b == 0) ? 8'hFC : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q[8*b +: 8] <= 8'h00;
      else if (wr_i && addr_i == 3'(OFS_PTR + b)) ptr_q[8*b +: 8] <= wdata_i & MASK;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      3'(OFS_CMD): begin
        rdata_o[CMD_RUN_BIT] = run_q;
        rdata_o[CMD_DIR_BIT] = dir_q;
      end
      3'(OFS_STS): begin
        rdata_o[STS_ACT_BIT] = busy_i;
        rdata_o[STS_ERR_BIT] = err_q;
        rdata_o[STS_INT_BIT] = intr_q;
        rdata_o[STS_CAP_LO+1:STS_CAP_LO] = cap_q;
      end
      default: begin
        for (int b = 0; b < PTR_BYTES; b++)
          if (addr_i == 3'(OFS_PTR + b)) rdata_o = ptr_q[8*b +: 8];
      end
    endcase
  end

  // R4
  dir_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(dir_q));
  // R6
  intr_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && wdata_i[STS_INT_BIT] && !drive_irq_i) |=> !intr_q);
  // R11
  intr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_irq_i |=> intr_q);
  // R7
  cap_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr |=> (cap_q == $past(wdata_i[STS_CAP_LO+1:STS_CAP_LO])));
endmodule

// File: rtl/bmd_walker.sv
module bmd_walker
  import bmd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              drive_irq_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  input  logic              xfer_ack_i,
  output logic              busy_o,
  output logic              fault_o
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL_LEN = {1'b1, {CNT_W{1'b0}}};
  localparam logic [REM_W-1:0] BEAT_R   = REM_W'(BEAT_BYTES);

  walk_state_e       state_q;
  logic [ADDR_W-1:0] ptr_q, addr_q;
  logic [REM_W-1:0]  rem_q;
  logic              last_q;
  logic [CNT_W-1:0]  cnt_field;
  logic              fetching;

  assign cnt_field   = mem_rdata_i[CNT_W-1:0];
  assign fetching    = (state_q == W_FETCH_BASE) || (state_q == W_FETCH_CNT);
  assign mem_req_o   = fetching;
  assign mem_addr_o  = (state_q == W_FETCH_CNT) ? ptr_q + ADDR_W'(4) : ptr_q;
  assign xfer_req_o  = (state_q == W_MOVE);
  assign xfer_addr_o = addr_q;
  assign busy_o      = (state_q != W_IDLE);
  assign fault_o     = fetching && mem_ack_i && mem_err_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      ptr_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      last_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= W_IDLE;
    end else if (start_i) begin
      state_q <= W_FETCH_BASE;
      ptr_q   <= ptr_i;
    end else begin
      case (state_q)
        W_FETCH_BASE: if (mem_ack_i) begin
          if (mem_err_i) state_q <= W_IDLE;
          else begin
            addr_q  <= mem_rdata_i[ADDR_W-1:0];
            state_q <= W_FETCH_CNT;
          end
        end
        W_FETCH_CNT: if (mem_ack_i) begin
          if (mem_err_i) state_q <= W_IDLE;
          else begin
            rem_q   <= (cnt_field == '0) ? FULL_LEN : {1'b0, cnt_field};
            last_q  <= mem_rdata_i[DESC_LAST_BIT];
            ptr_q   <= ptr_q + ADDR_W'(8);
            state_q <= W_MOVE;
          end
        end
        W_MOVE: if (xfer_ack_i) begin
          addr_q <= addr_q + ADDR_W'(BEAT_BYTES);
          if (rem_q <= BEAT_R) state_q <= last_q ? W_DRAIN : W_FETCH_BASE;
          else rem_q <= rem_q - BEAT_R;
        end
        W_DRAIN: if (drive_irq_i) state_q <= W_IDLE;
        default: state_q <= W_IDLE;
      endcase
    end
  end

  // R8
  one_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, xfer_req_o}));
  // R8
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !stop_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R3
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_o);
endmodule

// File: rtl/bmd_engine.sv
module bmd_engine
  import bmd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic              xfer_wr_mem_o,
  input  logic              xfer_ack_i,
  input  logic              drive_irq_i,
  output logic              irq_o
);
  logic              start, stop, dir, busy, fault;
  logic [ADDR_W-1:0] ptr;

  bmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .fault_i(fault), .drive_irq_i(drive_irq_i),
    .start_o(start), .stop_o(stop), .dir_o(dir), .ptr_o(ptr), .intr_o(irq_o)
  );

  bmd_walker #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start), .stop_i(stop), .ptr_i(ptr), .drive_irq_i(drive_irq_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_err_i(mem_err_i), .mem_rdata_i(mem_rdata_i),
    .xfer_req_o(xfer_req_o), .xfer_addr_o(xfer_addr_o), .xfer_ack_i(xfer_ack_i),
    .busy_o(busy), .fault_o(fault)
  );

  assign xfer_wr_mem_o = dir;

  // R12
  fetch_err_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i) |=> (!mem_req_o && !xfer_req_o));
endmodule

// File: tb/sim_bmd_engine.sv
module sim_bmd_engine;
  localparam logic [31:0] TBL = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_rdata = 32'd0;
  logic        xfer_req, xfer_wr_mem, xfer_ack = 1'b0;
  logic [31:0] xfer_addr;
  logic        drive_irq = 1'b0;
  logic        irq;

  always #2 clk = ~clk;

  bmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .xfer_req_o(xfer_req), .xfer_addr_o(xfer_addr), .xfer_wr_mem_o(xfer_wr_mem),
    .xfer_ack_i(xfer_ack), .drive_irq_i(drive_irq), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit timeout = 0;
  logic [31:0] tbl [16];
  logic [31:0] d_base [4];
  int d_len [4];
  int n_desc;
  int exp_di, exp_off, beats, bad_beats;
  bit exp_dir, slow, phase;
  logic [31:0] err_at = 32'hFFFF_FFFF;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tbl_word(input logic [31:0] a);
    if (a >= TBL && a < TBL + 64) return tbl[(a - TBL) >> 2];
    return 32'd0;
  endfunction

  // memory and drive FIFO responders
  always @(negedge clk) begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 32'd0; xfer_ack = 1'b0;
    if (mem_req && (!slow || phase)) begin
      mem_ack = 1'b1;
      if (mem_addr == err_at) mem_err = 1'b1;
      else mem_rdata = tbl_word(mem_addr);
    end
    if (xfer_req && (!slow || !phase)) begin
      xfer_ack = 1'b1;
      if (exp_di >= n_desc || xfer_addr !== d_base[exp_di] + 32'(exp_off) || xfer_wr_mem !== exp_dir)
        bad_beats++;
      beats++;
      if (exp_di < n_desc) begin
        exp_off += 4;
        if (exp_off >= d_len[exp_di]) begin exp_di++; exp_off = 0; end
      end
    end
    phase = ~phase;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_irq();
    @(negedge clk); drive_irq = 1'b1;
    @(negedge clk); drive_irq = 1'b0;
  endtask

  task automatic build_table();
    for (int i = 0; i < 16; i++) tbl[i] = 32'd0;
    for (int i = 0; i < n_desc; i++) begin
      tbl[2*i]   = d_base[i];
      tbl[2*i+1] = {(i == n_desc - 1), 15'd0, 16'(d_len[i] == 65536 ? 0 : d_len[i])};
    end
  endtask

  function automatic int total_beats();
    int t = 0;
    for (int i = 0; i < n_desc; i++) t += (d_len[i] + 3) / 4;
    return t;
  endfunction

  task automatic start_job(input bit dir);
    build_table();
    exp_di = 0; exp_off = 0; beats = 0; bad_beats = 0; exp_dir = dir;
    wr(3'd0, {4'd0, dir, 3'd0});
    for (int b = 0; b < 4; b++) wr(3'(4 + b), TBL[8*b +: 8]);
    wr(3'd0, {4'd0, dir, 3'b001});
  endtask

  task automatic wait_beats(input int n);
    while (beats < n && !timeout) @(negedge clk);
  endtask

  task automatic finish_job(input string tag);
    logic [7:0] s;
    int tot = total_beats();
    wait_beats(tot);
    repeat (4) @(negedge clk);
    rd(3'd2, s);
    // R10 draining after last beat
    chk(s[2:0] == 3'b001, {"R10 drain ", tag}, 32'(s), 32'h1);
    pulse_irq();
    rd(3'd2, s);
    // R10 clean finish pattern
    chk(s[2:0] == 3'b100 && irq, {"R10 done ", tag}, 32'(s), 32'h4);
    // R8 beat count and addresses, R4 direction per beat
    chk(beats == tot && bad_beats == 0, {"R8 R4 beats ", tag}, 32'(beats) | (32'(bad_beats) << 24), 32'(tot));
    wr(3'd2, 8'h06);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    fork
      begin : main
        logic [7:0] v;
        int held;
        slow = 0; phase = 0; n_desc = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
          rd(3'(a), v);
          chk(v == 8'h00, "R1 reg reset", 32'(v), 0);
        end
        chk(!irq && !mem_req && !xfer_req, "R1 outputs", {irq, mem_req, xfer_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 window layout
        for (int b = 0; b < 4; b++) wr(3'(4 + b), 8'(8'h13 + 8'h44 * b));
        for (int b = 0; b < 4; b++) begin
          rd(3'(4 + b), v);
          chk(v == (b == 0 ? 8'h10 : 8'(8'h13 + 8'h44 * b)), "R2 pointer byte", 32'(v), 32'(b));
        end
        wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
        rd(3'd1, v); chk(v == 8'h00, "R2 offset1", 32'(v), 0);
        rd(3'd3, v); chk(v == 8'h00, "R2 offset3", 32'(v), 0);
        // R7 / R5 capability bits stored, active read-only
        wr(3'd2, 8'h61);
        rd(3'd2, v); chk(v == 8'h60, "R7 R5 status write", 32'(v), 32'h60);
        wr(3'd2, 8'h20);
        rd(3'd2, v); chk(v == 8'h20, "R7 cap single", 32'(v), 32'h20);
        wr(3'd2, 8'h00);

        // sweep: single region, lengths 1..9, both directions (R8, R4)
        for (int dir = 0; dir < 2; dir++)
          for (int len = 1; len < 10; len++) begin
            n_desc = 1; d_base[0] = 32'h0002_0000 + 32'(len * 64); d_len[0] = len;
            slow = (len % 2 == 1);
            start_job(dir[0]);
            finish_job("sweep");
          end

        // three regions, interrupt while regions remain (R11), then W1C (R6)
        n_desc = 3; slow = 1;
        d_base[0] = 32'h0003_0000; d_len[0] = 24;
        d_base[1] = 32'h0005_0100; d_len[1] = 6;
        d_base[2] = 32'h0007_0200; d_len[2] = 40;
        start_job(1'b0);
        wait_beats(3);
        pulse_irq();
        rd(3'd2, v); chk(v[2:0] == 3'b101, "R11 mid irq", 32'(v), 32'h5);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk(v[2] == 1'b1, "R6 write zero keeps", 32'(v), 32'h5);
        wr(3'd2, 8'h04);
        rd(3'd2, v); chk(v[2:0] == 3'b001, "R6 W1C intr", 32'(v), 32'h1);
        finish_job("multi");
        rd(3'd2, v); chk(v == 8'h00, "R6 W1C after done", 32'(v), 0);

        // R9 count 0 means 65536 bytes
        n_desc = 1; slow = 0; d_base[0] = 32'h0010_0000; d_len[0] = 65536;
        start_job(1'b1);
        finish_job("R9 64K");

        // R4 direction write ignored while running
        n_desc = 1; slow = 1; d_base[0] = 32'h0040_0000; d_len[0] = 64;
        start_job(1'b1);
        wait_beats(2);
        wr(3'd0, 8'h01);
        rd(3'd0, v); chk(v == 8'h09, "R4 dir frozen", 32'(v), 32'h09);
        finish_job("R4 dir");

        // R12 fetch error on second descriptor
        n_desc = 2; slow = 1;
        d_base[0] = 32'h0050_0000; d_len[0] = 12;
        d_base[1] = 32'h0060_0000; d_len[1] = 12;
        err_at = TBL + 8;
        start_job(1'b0);
        held = 0;
        v = 8'h01;
        while (v[0] && held < 200) begin rd(3'd2, v); held++; end
        chk(v[2:0] == 3'b010, "R12 error pattern", 32'(v), 32'h2);
        chk(beats == 3, "R12 beats before error", 32'(beats), 3);
        repeat (10) @(negedge clk);
        chk(!mem_req && !xfer_req && beats == 3, "R12 halted", {mem_req, xfer_req}, 0);
        wr(3'd2, 8'h02);
        rd(3'd2, v); chk(v[2:0] == 3'b000, "R6 W1C err", 32'(v), 0);
        wr(3'd0, 8'h00);
        err_at = 32'hFFFF_FFFF;

        // R3 stop mid-transfer
        n_desc = 1; slow = 1; d_base[0] = 32'h0070_0000; d_len[0] = 4096;
        start_job(1'b1);
        rd(3'd2, v); chk(v[0] == 1'b1, "R5 active on start", 32'(v), 1);
        wait_beats(5);
        wr(3'd0, 8'h08);
        rd(3'd2, v); chk(v[2:0] == 3'b000, "R3 stop clears active", 32'(v), 0);
        held = beats;
        repeat (20) @(negedge clk);
        chk(beats == held && !xfer_req && !mem_req, "R3 no beats after stop", 32'(beats), 32'(held));
        chk(!irq, "R10 irq low without drive", 32'(irq), 0);
      end
      begin : dog
        repeat (190000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finish");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule